// File: doc/BRIEF.md
# Encoder Electrical Angle Tracker

This block turns a free-running incremental position count into an electrical angle for one motor axis. It keeps a running offset so that the count minus the offset stays inside one electrical period. Each time an update is taken, it publishes that wrapped index, the new offset and a full-turn phase word. The phase word is meant to drive a separate sine/cosine generator.

No division is used anywhere. When the difference between the count and the offset leaves the window [0, period), the offset moves by exactly one period toward the count, and the index is formed again. Because only one step is taken per update, the count may move by less than one period between two updates. The phase word is the index times a caller-supplied reciprocal of the period, truncated to 32 bits. With that reciprocal, one period spans one full turn of the phase word.

Several count sources share one input bus. A binary select field picks which of them feeds this axis on each update. Updates use a valid/ready handshake, and a one-cycle done pulse marks fresh outputs.

Top module: `eat_tracker`

## Requirements
- R1: While reset is asserted, and after it is released, `ang_offset`, `ang_index` and `ang_phase` read zero, `upd_done` is low and `upd_ready` is high.
- R2: On an accepted update, let D = count − offset (32-bit wraparound). If D, read as unsigned, is below `period`, then `ang_index` becomes D and `ang_offset` keeps its value.
- R3: If D, read as unsigned, is at least `period` and D bit 31 is 0, then the offset grows by `period` and the index becomes count minus the new offset. A count exactly one period above the offset therefore gives index 0.
- R4: If D, read as unsigned, is at least `period` and D bit 31 is 1, then the offset shrinks by `period` and the index becomes count minus the new offset. This also holds when the count wraps through zero.
- R5: Each update makes at most one offset correction. After a jump of more than one period, the published index can still be at or above `period`.
- R6: `ang_phase` equals `ang_index` × `recip`, keeping the low 32 bits, with `recip` sampled on the accepting edge.
- R7: `src_sel` is a binary slot number. Slot k of `cnt_bus` sits in bits [32k+31:32k], and only the selected slot affects the result.
- R8: `upd_done` is high for exactly the one cycle after an accepted update (`upd_valid` and `upd_ready` both high on a rising edge). The outputs hold their values in every cycle without an accepted update.
- R9: `upd_ready` is low while `upd_done` is high. `upd_valid` in that cycle is ignored: it changes no output and gives no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Update request |
| upd_ready | output | 1 | Update can be accepted this cycle |
| src_sel | input | 2 | Count source slot number |
| cnt_bus | input | 128 | Four packed 32-bit position counts |
| period | input | 32 | Counts per electrical period |
| recip | input | 32 | Phase scale, about 2^32 / period |
| ang_index | output | 32 | Wrapped electrical index |
| ang_offset | output | 32 | Current offset register |
| ang_phase | output | 32 | Full-turn phase word |
| upd_done | output | 1 | One-cycle pulse marking fresh outputs |

## Verification
Several properties are checked on every cycle:
- the done pulse lasts one cycle and follows exactly the accepted updates;
- ready is withheld during done;
- the outputs hold between updates;
- each update moves the offset by zero or by exactly one period;
- the phase word matches the index times the sampled reciprocal.

Which way the offset moves, at which boundary the wrap happens, and the arithmetic through the 32-bit wrap are shown only by the bench's vectors. The same holds for source selection, the lone correction after a large jump, and a request dropped during done.

// File: rtl/eat_pkg.sv
package eat_pkg;
   localparam int unsigned EAT_W_DEF    = 32;
   localparam int unsigned EAT_NSRC_DEF = 4;

   function automatic int unsigned sel_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/eat_src_mux.sv
module eat_src_mux #(
   parameter int unsigned W    = 32,
   parameter int unsigned NSRC = 4,
   localparam int unsigned SELW = eat_pkg::sel_width(NSRC)
) (
   input  logic [NSRC*W-1:0] bus,
   input  logic [SELW-1:0]   sel,
   output logic [W-1:0]      cnt
);
   logic [W-1:0] slot [NSRC];

   for (genvar k = 0; k < NSRC; k++) begin : g_slot
      assign slot[k] = bus[k*W +: W];
   end

   always_comb begin
      cnt = slot[0];
      for (int k = 1; k < NSRC; k++) begin
         if (int'(sel) == k) cnt = slot[k];
      end
   end
endmodule

// File: rtl/eat_wrap.sv
module eat_wrap #(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] off,
   input  logic [W-1:0] per,
   output logic [W-1:0] idx_nxt,
   output logic [W-1:0] off_nxt
);
   logic [W-1:0] diff;
   logic         outside;

   assign diff    = cnt - off;
   assign outside = (diff >= per);

   always_comb begin
      off_nxt = off;
      if (outside) begin
         if (diff[W-1]) off_nxt = off - per;
         else           off_nxt = off + per;
      end
      idx_nxt = cnt - off_nxt;
   end
endmodule

// File: rtl/eat_scale.sv
module eat_scale #(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] idx,
   input  logic [W-1:0] rec,
   output logic [W-1:0] phase
);
   assign phase = idx * rec;
endmodule

// File: rtl/eat_tracker.sv
module eat_tracker #(
   parameter int unsigned W    = eat_pkg::EAT_W_DEF,
   parameter int unsigned NSRC = eat_pkg::EAT_NSRC_DEF,
   localparam int unsigned SELW = eat_pkg::sel_width(NSRC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_valid,
   output logic              upd_ready,
   input  logic [SELW-1:0]   src_sel,
   input  logic [NSRC*W-1:0] cnt_bus,
   input  logic [W-1:0]      period,
   input  logic [W-1:0]      recip,
   output logic [W-1:0]      ang_index,
   output logic [W-1:0]      ang_offset,
   output logic [W-1:0]      ang_phase,
   output logic              upd_done
);
   if (W < 8) begin : g_bad_w
      $error("eat_tracker: W must be at least 8");
   end
   if (NSRC < 1) begin : g_bad_n
      $error("eat_tracker: NSRC must be at least 1");
   end

   logic [W-1:0] cnt_sel;
   logic [W-1:0] idx_nxt;
   logic [W-1:0] off_nxt;
   logic [W-1:0] phase_nxt;
   logic         accept;

   assign upd_ready = ~upd_done;
   assign accept    = upd_valid & upd_ready;

   eat_src_mux #(.W(W), .NSRC(NSRC)) u_mux (
      .bus (cnt_bus),
      .sel (src_sel),
      .cnt (cnt_sel)
   );

   eat_wrap #(.W(W)) u_wrap (
      .cnt     (cnt_sel),
      .off     (ang_offset),
      .per     (period),
      .idx_nxt (idx_nxt),
      .off_nxt (off_nxt)
   );

   eat_scale #(.W(W)) u_scale (
      .idx   (idx_nxt),
      .rec   (recip),
      .phase (phase_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ang_offset <= '0;
         ang_index  <= '0;
         ang_phase  <= '0;
         upd_done   <= 1'b0;
      end else begin
         upd_done <= accept;
         if (accept) begin
            ang_offset <= off_nxt;
            ang_index  <= idx_nxt;
            ang_phase  <= phase_nxt;
         end
      end
   end
endmodule

// File: rtl/eat_tracker_chk.sv
module eat_tracker_chk #(
   parameter int unsigned W    = 32,
   parameter int unsigned NSRC = 4,
   localparam int unsigned SELW = eat_pkg::sel_width(NSRC)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              upd_valid,
   input logic              upd_ready,
   input logic [SELW-1:0]   src_sel,
   input logic [NSRC*W-1:0] cnt_bus,
   input logic [W-1:0]      period,
   input logic [W-1:0]      recip,
   input logic [W-1:0]      ang_index,
   input logic [W-1:0]      ang_offset,
   input logic [W-1:0]      ang_phase,
   input logic              upd_done
);
   AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_ready) |=> upd_done); // R8
   AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !(upd_valid && upd_ready) |=> !upd_done); // R9
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      upd_done |=> !upd_done); // R8
   AST_READY_WITHHELD: assert property (@(posedge clk) disable iff (!rst_n)
      upd_done |-> !upd_ready); // R9
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(upd_valid && upd_ready) |=> ($stable(ang_index) && $stable(ang_offset) && $stable(ang_phase))); // R8
   AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_ready) |=> (ang_offset == $past(ang_offset) ||
                                    ang_offset == $past(ang_offset) + $past(period) ||
                                    ang_offset == $past(ang_offset) - $past(period))); // R5
   AST_PHASE_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_ready) |=> (ang_phase == W'(ang_index * $past(recip)))); // R6
endmodule

bind eat_tracker eat_tracker_chk #(.W(W), .NSRC(NSRC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .upd_valid  (upd_valid),
   .upd_ready  (upd_ready),
   .src_sel    (src_sel),
   .cnt_bus    (cnt_bus),
   .period     (period),
   .recip      (recip),
   .ang_index  (ang_index),
   .ang_offset (ang_offset),
   .ang_phase  (ang_phase),
   .upd_done   (upd_done)
);

// File: tb/sim_eat_tracker.sv
module sim_eat_tracker;
   localparam int unsigned W    = 32;
   localparam int unsigned NSRC = 4;
   localparam int unsigned NV   = 12;

   localparam logic [1:0]  V_SEL [NV] = '{0, 0, 0, 0, 1, 2, 3, 0, 0, 0, 1, 2};
   localparam logic [31:0] V_CNT [NV] = '{32'd0, 32'd500, 32'd999, 32'd1000, 32'd1700, 32'd2300,
                                          32'd1999, 32'd5, 32'hFFFF_FFF0, 32'h0000_0010, 32'd800, 32'd900};
   localparam logic [31:0] V_PER [NV] = '{1000, 1000, 1000, 1000, 1000, 1000, 1000, 1000, 1000, 1000, 360, 360};
   localparam logic [31:0] V_REC [NV] = '{4294967, 4294967, 4294967, 4294967, 4294967, 4294967,
                                          4294967, 4294967, 4294967, 4294967, 11930465, 11930465};
   localparam logic [31:0] V_IDX [NV] = '{32'd0, 32'd500, 32'd999, 32'd0, 32'd700, 32'd300,
                                          32'd999, 32'd5, 32'd984, 32'd16, 32'd440, 32'd180};
   localparam logic [31:0] V_OFF [NV] = '{32'd0, 32'd0, 32'd0, 32'd1000, 32'd1000, 32'd2000,
                                          32'd1000, 32'd0, 32'hFFFF_FC18, 32'd0, 32'd360, 32'd720};
   localparam string V_REQ [NV] = '{"R2", "R2", "R2", "R3", "R7", "R3", "R4", "R4", "R4", "R3", "R5", "R5"};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              upd_valid = 1'b0;
   logic              upd_ready;
   logic [1:0]        src_sel = '0;
   logic [NSRC*W-1:0] cnt_bus = '0;
   logic [W-1:0]      period = 32'd1000;
   logic [W-1:0]      recip = 32'd4294967;
   logic [W-1:0]      ang_index;
   logic [W-1:0]      ang_offset;
   logic [W-1:0]      ang_phase;
   logic              upd_done;

   int checks = 0;
   int fails  = 0;
   bit ended  = 0;

   always #2 clk = ~clk;

   eat_tracker #(.W(W), .NSRC(NSRC)) u0 (
      .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_ready(upd_ready),
      .src_sel(src_sel), .cnt_bus(cnt_bus), .period(period), .recip(recip),
      .ang_index(ang_index), .ang_offset(ang_offset), .ang_phase(ang_phase),
      .upd_done(upd_done)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic load_bus(input logic [1:0] s, input logic [31:0] v);
      for (int k = 0; k < NSRC; k++) begin
         cnt_bus[k*W +: W] = (k == int'(s)) ? v : (32'hA5A5_0000 + 32'(k) * 32'd7777);
      end
      src_sel = s;
   endtask

   // issues one update; returns at the negedge where done is high
   task automatic apply(input logic [1:0] s, input logic [31:0] v, input logic [31:0] p, input logic [31:0] r);
      while (!upd_ready) @(negedge clk);
      load_bus(s, v);
      period    = p;
      recip     = r;
      upd_valid = 1'b1;
      @(negedge clk);
      upd_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!ended) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] hold_idx;
      load_bus(2'd0, 32'd0);
      repeat (3) @(negedge clk);
      // R1: state held in reset
      chk("R1", "offset in reset", ang_offset, 32'd0);
      chk("R1", "index in reset", ang_index, 32'd0);
      chk("R1", "phase in reset", ang_phase, 32'd0);
      chk("R1", "done in reset", {31'd0, upd_done}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "ready after reset", {31'd0, upd_ready}, 32'd1);

      for (int i = 0; i < NV; i++) begin
         apply(V_SEL[i], V_CNT[i], V_PER[i], V_REC[i]);
         chk(V_REQ[i], "index", ang_index, V_IDX[i]);
         chk(V_REQ[i], "offset", ang_offset, V_OFF[i]);
         chk("R6", "phase", ang_phase, V_IDX[i] * V_REC[i]);
         chk("R8", "done pulse", {31'd0, upd_done}, 32'd1);
         @(negedge clk);
         chk("R8", "done drops", {31'd0, upd_done}, 32'd0);
         chk("R8", "index holds", ang_index, V_IDX[i]);
      end

      // R9: request during done is ignored
      apply(2'd2, 32'd1000, 32'd360, 32'd11930465);
      chk("R2", "index off 720", ang_index, 32'd280);
      chk("R9", "ready low in done", {31'd0, upd_ready}, 32'd0);
      hold_idx  = ang_index;
      load_bus(2'd2, 32'd5000);
      upd_valid = 1'b1;
      @(negedge clk);
      upd_valid = 1'b0;
      chk("R9", "no done from blocked request", {31'd0, upd_done}, 32'd0);
      chk("R9", "index unchanged", ang_index, hold_idx);
      chk("R9", "offset unchanged", ang_offset, 32'd720);

      // R1: reset mid-run clears state
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1", "offset cleared", ang_offset, 32'd0);
      chk("R1", "index cleared", ang_index, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule